// File: doc/BRIEF.md
# Shared Reservation Monitor for Load-Linked / Store-Conditional

This block arbitrates atomic read-modify-write sequences among several cores that share one memory. For each core it holds one reservation entry: whether a reservation is open or armed, the reserved address, whether the core currently participates, and a small counter that sets the pace of forced failures. Every core offers one operation at a time on its own request port: load-linked, plain store, store-conditional or detach. The monitor then decides whether a store-conditional is allowed to update memory. The memory data path and the cores' private monitors sit outside the block. The private monitor's verdict enters on `local_ok`.

One request is accepted per clock, so a reservation update is never interleaved with another one. Each request port is valid/ready. A core raises `req_valid` and holds its kind, address and `local_ok` unchanged until it sees `req_ready` high at a rising edge. `req_ready` is asserted for only one core in a cycle: the lowest-numbered core that has a valid request. The other cores are back-pressured and stay pending. A store-conditional gets its verdict on `rsp_valid`/`rsp_pass` one clock after it is accepted. Those outputs carry no back-pressure; they are a one-cycle strobe.

The verdict is 1 only when both monitors agree, the private one and this shared one. Memory is written only then. On every sixth qualifying store-conditional of a core, the shared monitor fails it on purpose, so that software retry loops get exercised the way spurious hardware losses would exercise them.

Top module: `excl_monitor_hub`

## Requirements
- R1: When several cores request in the same cycle, `req_ready` is high for the lowest-numbered requesting core only. The other cores see `req_ready` low and keep their request pending until they are granted. With no request, `req_ready` is all zero.
- R2: A store-conditional accepted at edge T drives `rsp_valid` high for that core alone during the cycle after T. Load-linked, store and detach requests produce no response. `rsp_pass` is never high without `rsp_valid`.
- R3: A load-linked (kind 0) arms the core's reservation on its address. A store-conditional (kind 2) from that core to exactly that address passes and disarms the reservation, so an immediate repeat fails.
- R4: A store-conditional from a core with no armed reservation fails.
- R5: A store-conditional whose address differs from the reserved one fails, and the reservation stays armed, so a later store-conditional to the reserved address passes.
- R6: A plain store (kind 1) from any core disarms every armed reservation.
- R7: A passing store-conditional disarms the reservations of all other participating cores, including a reservation on a different address in the same 8-byte granule.
- R8: Each core counts its qualifying store-conditionals. Five pass, the sixth is forced to fail and the count restarts. A forced failure disarms only the requester and leaves other cores' reservations armed.
- R9: With `local_ok` low, a store-conditional fails and leaves the shared monitor's state unchanged. A reservation that was armed stays armed.
- R10: A detach request (kind 3) withdraws the core from participation and disarms its entry. Its store-conditional fails until it issues a new load-linked.
- R11: After reset every entry is disarmed, every counter is zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_ready | output | NUM_CORES | Per-core accept, one-hot or zero |
| req_kind | input | 2*NUM_CORES | Per-core kind: 0 load-linked, 1 store, 2 store-conditional, 3 detach |
| req_addr | input | NUM_CORES*ADDR_W | Per-core byte address |
| local_ok | input | NUM_CORES | Private-monitor verdict accompanying a store-conditional |
| rsp_valid | output | NUM_CORES | Store-conditional verdict strobe |
| rsp_pass | output | NUM_CORES | Store-conditional verdict, 1 = memory may be written |

## Verification
Several properties are checked on every cycle. At most one grant is issued, and only to a valid core. The grant goes to the lowest-numbered requester. A response strobe appears exactly where a store-conditional was accepted one cycle earlier. A pass never occurs without a pass from the private monitor. Whether a verdict is right depends on the history of reservations, and only the bench's scenarios can show that. Those scenarios cover exact versus mismatched addresses, a store from another core, cross-core invalidation after a success, the forced sixth failure and its locality, vetoes by the private monitor, and detach.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_LL     = 2'd0,
    OP_ST     = 2'd1,
    OP_SC     = 2'd2,
    OP_DETACH = 2'd3
  } op_kind_e;
endpackage

// File: rtl/excl_prio_arb.sv
module excl_prio_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/excl_core_entry.sv
module excl_core_entry
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FAIL_LIMIT  = 5,
  parameter int GRAN_BITS   = 3,
  parameter bit SC_AS_STORE = 1'b1,
  localparam int CW = $clog2(FAIL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_fire,
  input  op_kind_e          op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              is_req,
  input  logic              op_local_ok,
  input  logic              sc_success,
  output logic              glob_pass
);
  logic              armed_q;
  logic              member_q;
  logic [ADDR_W-1:0] tag_q;
  logic [CW-1:0]     cnt_q;

  logic exact_hit, gran_hit, below_limit, qualify, peer_clear;

  assign exact_hit   = (tag_q == op_addr);
  assign gran_hit    = (tag_q[ADDR_W-1:GRAN_BITS] == op_addr[ADDR_W-1:GRAN_BITS]);
  assign below_limit = (cnt_q < CW'(FAIL_LIMIT));
  assign qualify     = op_fire && is_req && (op_kind == OP_SC) && op_local_ok
                       && armed_q && exact_hit;
  assign glob_pass   = qualify && below_limit;

  // Peers lose their reservation on a granule hit; when a success also
  // counts as a store, every armed peer is released.
  generate
    if (SC_AS_STORE) begin : g_store_effect
      assign peer_clear = 1'b1;
    end else begin : g_granule_only
      assign peer_clear = gran_hit;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      member_q <= 1'b0;
      tag_q    <= '0;
      cnt_q    <= '0;
    end else if (op_fire) begin
      unique case (op_kind)
        OP_LL: begin
          if (is_req) begin
            armed_q  <= 1'b1;
            member_q <= 1'b1;
            tag_q    <= op_addr;
          end
        end
        OP_ST: begin
          if (member_q && armed_q) armed_q <= 1'b0;
        end
        OP_SC: begin
          if (qualify) begin
            armed_q <= 1'b0;
            cnt_q   <= below_limit ? cnt_q + CW'(1) : '0;
          end else if (!is_req && sc_success && member_q && armed_q && peer_clear) begin
            armed_q <= 1'b0;
          end
        end
        OP_DETACH: begin
          if (is_req) begin
            member_q <= 1'b0;
            armed_q  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/excl_monitor_hub.sv
module excl_monitor_hub
  import excl_mon_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int ADDR_W     = 32,
  parameter int FAIL_LIMIT = 5,
  parameter int GRAN_BITS  = 3,
  localparam int IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  output logic [NUM_CORES-1:0]        req_ready,
  input  logic [2*NUM_CORES-1:0]      req_kind,
  input  logic [NUM_CORES*ADDR_W-1:0] req_addr,
  input  logic [NUM_CORES-1:0]        local_ok,
  output logic [NUM_CORES-1:0]        rsp_valid,
  output logic [NUM_CORES-1:0]        rsp_pass
);
  logic [NUM_CORES-1:0] gnt;
  logic [IW-1:0]        gidx;
  logic                 any_gnt;
  op_kind_e             sel_kind;
  logic [ADDR_W-1:0]    sel_addr;
  logic                 sel_lok;
  logic [NUM_CORES-1:0] pass_vec;
  logic                 sc_success;
  logic                 sc_fire;

  excl_prio_arb #(.N(NUM_CORES)) arb_i (
    .req     (req_valid),
    .gnt     (gnt),
    .gnt_idx (gidx),
    .any     (any_gnt)
  );

  assign req_ready  = gnt;
  assign sel_kind   = op_kind_e'(req_kind[gidx*2 +: 2]);
  assign sel_addr   = req_addr[gidx*ADDR_W +: ADDR_W];
  assign sel_lok    = local_ok[gidx];
  assign sc_success = |pass_vec;
  assign sc_fire    = any_gnt && (sel_kind == OP_SC);

  generate
    for (genvar i = 0; i < NUM_CORES; i++) begin : g_entry
      excl_core_entry #(
        .ADDR_W     (ADDR_W),
        .FAIL_LIMIT (FAIL_LIMIT),
        .GRAN_BITS  (GRAN_BITS)
      ) entry_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_fire     (any_gnt),
        .op_kind     (sel_kind),
        .op_addr     (sel_addr),
        .is_req      (gnt[i]),
        .op_local_ok (sel_lok),
        .sc_success  (sc_success),
        .glob_pass   (pass_vec[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_pass  <= '0;
    end else begin
      rsp_valid <= sc_fire ? gnt : '0;
      rsp_pass  <= (sc_fire && sc_success) ? gnt : '0;
    end
  end
endmodule

// File: rtl/excl_monitor_hub_chk.sv
module excl_monitor_hub_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES-1:0]   req_valid,
  input logic [NUM_CORES-1:0]   req_ready,
  input logic [2*NUM_CORES-1:0] req_kind,
  input logic [NUM_CORES-1:0]   local_ok,
  input logic [NUM_CORES-1:0]   rsp_valid,
  input logic [NUM_CORES-1:0]   rsp_pass
);
  logic [NUM_CORES-1:0] sc_taken;
  logic [NUM_CORES-1:0] lowest_valid;

  always_comb begin
    for (int i = 0; i < NUM_CORES; i++)
      sc_taken[i] = req_valid[i] && req_ready[i] && (req_kind[2*i +: 2] == 2'd2);
  end
  assign lowest_valid = req_valid & (~req_valid + NUM_CORES'(1));

  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  p_lowest_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == lowest_valid);
  p_rsp_follows_sc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(sc_taken));
  p_pass_within_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_pass & ~rsp_valid) == '0);
  p_pass_needs_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_pass & ~$past(local_ok)) == '0);
endmodule

bind excl_monitor_hub excl_monitor_hub_chk #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .local_ok  (local_ok),
  .rsp_valid (rsp_valid),
  .rsp_pass  (rsp_pass)
);

// File: tb/excl_monitor_hub_tb.sv
`timescale 1ns/1ps
module excl_monitor_hub_tb_top;
  localparam int NC = 4;
  localparam int AW = 32;
  localparam logic [1:0] K_LL = 2'd0, K_ST = 2'd1, K_SC = 2'd2, K_DT = 2'd3;
  localparam logic [1:0] E_FAIL = 2'd0, E_PASS = 2'd1, E_NONE = 2'd2;
  localparam int NV = 19;

  // {req tag number, core, kind, addr, local_ok, expectation}
  localparam logic [42:0] VEC [NV] = '{
    {4'd3,  2'd0, K_LL, 32'h100, 1'b1, E_NONE},
    {4'd3,  2'd0, K_SC, 32'h100, 1'b1, E_PASS},  // R3 exact hit
    {4'd3,  2'd0, K_SC, 32'h100, 1'b1, E_FAIL},  // R3/R4 disarmed
    {4'd7,  2'd0, K_LL, 32'h100, 1'b1, E_NONE},
    {4'd7,  2'd1, K_LL, 32'h104, 1'b1, E_NONE},
    {4'd7,  2'd0, K_SC, 32'h100, 1'b1, E_PASS},
    {4'd7,  2'd1, K_SC, 32'h104, 1'b1, E_FAIL},  // R7 same granule peer
    {4'd5,  2'd1, K_LL, 32'h200, 1'b1, E_NONE},
    {4'd5,  2'd1, K_SC, 32'h204, 1'b1, E_FAIL},  // R5 mismatch
    {4'd5,  2'd1, K_SC, 32'h200, 1'b1, E_PASS},  // R5 kept
    {4'd6,  2'd2, K_LL, 32'h300, 1'b1, E_NONE},
    {4'd6,  2'd3, K_ST, 32'h900, 1'b1, E_NONE},
    {4'd6,  2'd2, K_SC, 32'h300, 1'b1, E_FAIL},  // R6 store clears
    {4'd9,  2'd2, K_LL, 32'h300, 1'b1, E_NONE},
    {4'd9,  2'd2, K_SC, 32'h300, 1'b0, E_FAIL},  // R9 veto
    {4'd9,  2'd2, K_SC, 32'h300, 1'b1, E_PASS},  // R9 still armed
    {4'd10, 2'd3, K_LL, 32'h400, 1'b1, E_NONE},
    {4'd10, 2'd3, K_DT, 32'h400, 1'b1, E_NONE},
    {4'd10, 2'd3, K_SC, 32'h400, 1'b1, E_FAIL}   // R10 detached
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC-1:0]     req_ready;
  logic [2*NC-1:0]   req_kind = '0;
  logic [NC*AW-1:0]  req_addr = '0;
  logic [NC-1:0]     local_ok = '0;
  logic [NC-1:0]     rsp_valid;
  logic [NC-1:0]     rsp_pass;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  excl_monitor_hub #(.NUM_CORES(NC), .ADDR_W(AW)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_addr,
    .local_ok, .rsp_valid, .rsp_pass
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input int c, input logic [1:0] k, input logic [31:0] a, input logic lok);
    req_valid[c]          = 1'b1;
    req_kind[2*c +: 2]    = k;
    req_addr[c*AW +: AW]  = a;
    local_ok[c]           = lok;
  endtask

  // single request: accepted at the next edge, verdict seen after it
  task automatic issue(input string tag, input int c, input logic [1:0] k,
                       input logic [31:0] a, input logic lok, input logic [1:0] e);
    @(negedge clk);
    load(c, k, a, lok);
    @(posedge clk);
    @(negedge clk);
    req_valid[c] = 1'b0;
    if (e == E_NONE) begin
      check({tag, " R2 no response"}, 32'(rsp_valid), 32'h0);
    end else begin
      check({tag, " R2 strobe"}, 32'(rsp_valid), 32'(1 << c));
      check({tag, " verdict"}, 32'(rsp_pass[c]), 32'(e == E_PASS));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 ready idle", 32'(req_ready), 32'h0);
    check("R11 rsp idle", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    issue("R11 unarmed after reset", 1, K_SC, 32'h0, 1'b1, E_FAIL);

    for (int v = 0; v < NV; v++) begin
      issue($sformatf("R%0d vec%0d", VEC[v][42:39], v), int'(VEC[v][38:37]),
            VEC[v][36:35], VEC[v][34:3], VEC[v][2], VEC[v][1:0]);
    end

    // R8: core0 has 2 qualifying passes so far; three more reach the limit
    for (int n = 0; n < 3; n++) begin
      issue("R8 ll", 0, K_LL, 32'h500, 1'b1, E_NONE);
      issue("R8 pass before limit", 0, K_SC, 32'h500, 1'b1, E_PASS);
    end
    issue("R8 ll", 0, K_LL, 32'h500, 1'b1, E_NONE);
    issue("R8 peer ll", 1, K_LL, 32'h504, 1'b1, E_NONE);
    issue("R8 forced sixth", 0, K_SC, 32'h500, 1'b1, E_FAIL);
    issue("R8 peer unaffected", 1, K_SC, 32'h504, 1'b1, E_PASS);
    issue("R8 ll", 0, K_LL, 32'h500, 1'b1, E_NONE);
    issue("R8 counter restarted", 0, K_SC, 32'h500, 1'b1, E_FAIL + E_PASS);

    // R1 arbitration: cores 1 and 2 together
    @(negedge clk);
    load(2, K_LL, 32'h600, 1'b1);
    load(1, K_LL, 32'h700, 1'b1);
    #1 check("R1 lowest first", 32'(req_ready), 32'h2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1 check("R1 pending served next", 32'(req_ready), 32'h4);
    @(negedge clk);
    req_valid[2] = 1'b0;
    #1 check("R1 idle after both", 32'(req_ready), 32'h0);
    issue("R1 core1 reserved", 1, K_SC, 32'h700, 1'b1, E_PASS);
    issue("R7 core2 released by peer pass", 2, K_SC, 32'h600, 1'b1, E_FAIL);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule